// File: doc/BRIEF.md
# JTAG to Debug Bus Bridge

This block lets an external host drive a small request/acknowledge debug bus through a user data register of a JTAG TAP. The host shifts one command frame through the register. The frame holds an operation code, a data word and an address. When the TAP issues its update pulse, the block latches the command. It then carries the command into the system clock domain, where it runs one read or one write on the debug bus.

On each later capture pulse, the block loads a response frame into the same register, with the same layout as the command. The response holds a status code, the last read data and the address of the last accepted command. The host keeps capturing until the status shows that the transaction is complete.

The two clock domains meet through toggle flags, each passed through a two-flop synchronizer. The command and response fields are held steady for as long as the toggles say the other side may sample them. The TAP state machine itself lives outside this block.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: The data register is AW+DW+2 bits long (74 by default). The frame is laid out as {address, data, op}, with op in bits [1:0], data in bits [DW+1:2] and the address in the top AW bits. On each TCK rising edge with shift high, the register moves one bit toward bit 0, tdi enters at the top, and tdo always shows bit 0.
- R2: Capture, shift and update act only when chain_sel equals 4'b0010. Any other select value, including one with several bits set, leaves the register and the bus untouched.
- R3: A command with op 01 (read) that is accepted on update causes exactly one debug bus read at that address with bus_we low. The value on bus_rdata at the acknowledge cycle is returned in the data field of later response frames.
- R4: A command with op 10 (write) that is accepted on update causes exactly one debug bus write of the data field to that address, with bus_we high.
- R5: bus_req stays high, and bus_addr, bus_we and bus_wdata stay stable, until a cycle with bus_ack high. bus_req is low in the following cycle.
- R6: The status field of a captured response is 11 while an accepted transaction has not yet completed, and 00 otherwise.
- R7: A command with op 00 or 11 starts no bus transaction and does not change the address reported in responses.
- R8: A read or write command that arrives while a transaction is pending is dropped. It causes no bus transaction, and the response still reports the pending command's address.
- R9: While tap_rst is high, the shift register and the pending flag are cleared, the reported address returns to 0, and the next response shows status 00. Commands accepted after the reset work normally.
- R10: The response data field keeps the data from the most recent completed read. A completed write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| tap_rst | input | 1 | TAP reset, synchronous to tck, active high |
| tdi | input | 1 | Serial data into the register |
| tdo | output | 1 | Serial data out of the register (bit 0) |
| cap_en | input | 1 | Capture pulse: load the response frame |
| shift_en | input | 1 | Shift enable |
| upd_en | input | 1 | Update pulse: latch and launch the command |
| chain_sel | input | 4 | One-hot user chain select, this block is 4'b0010 |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | System reset, synchronous, active high |
| bus_addr | output | AW | Debug bus address |
| bus_wdata | output | DW | Debug bus write data |
| bus_rdata | input | DW | Debug bus read data |
| bus_req | output | 1 | Debug bus request |
| bus_we | output | 1 | Debug bus write strobe (1 write, 0 read) |
| bus_ack | input | 1 | Debug bus acknowledge |

## Verification
The hardest case to reach is a second command or a TAP reset that lands while a transaction is still in flight. A fast bus responder completes every transaction before the host can shift the next frame, so neither case would ever occur. The bench's bus model therefore takes a programmable acknowledge delay of thousands of system cycles. It launches a command and shifts the follow-up frame, or pulses tap_rst, inside that window. It then checks at the bus and in later responses that the intruding command left no trace, and that the reset cleared the status.

// File: rtl/jdb_pkg.sv
package jdb_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  localparam logic [OP_W-1:0] ST_IDLE = 2'b00;
  localparam logic [OP_W-1:0] ST_BUSY = 2'b11;

  // Only read and write start a bus transaction.
  function automatic logic op_launches(input logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic [OP_W-1:0] status_code(input logic busy);
    return busy ? ST_BUSY : ST_IDLE;
  endfunction

endpackage

// File: rtl/jdb_sync.sv
module jdb_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) stage[0] <= d;

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) stage[s] <= stage[s-1];
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/jdb_tck_side.sv
module jdb_tck_side
  import jdb_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 64,
  parameter int SEL_W   = 4,
  parameter int SEL_IDX = 1
) (
  input  logic          tck,
  input  logic          tap_rst,
  input  logic          tdi,
  output logic          tdo,
  input  logic          cap_en,
  input  logic          shift_en,
  input  logic          upd_en,
  input  logic [SEL_W-1:0] chain_sel,
  input  logic          done_tog_a,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_we,
  output logic          req_tog,
  output logic          busy,
  output logic          launch
);
  localparam int FW = AW + DW + OP_W;
  localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(1) << SEL_IDX;

  logic [FW-1:0]   sr;
  logic [OP_W-1:0] fr_op;
  logic [DW-1:0]   fr_data;
  logic [AW-1:0]   fr_addr;
  logic            sel_hit;
  logic            done_s;
  logic            done_seen;
  logic            done_evt;

  assign fr_op   = sr[OP_W-1:0];
  assign fr_data = sr[DW+OP_W-1:OP_W];
  assign fr_addr = sr[FW-1:DW+OP_W];
  assign sel_hit = (chain_sel == SEL_CODE);
  assign launch  = sel_hit && upd_en && op_launches(fr_op) && !busy;
  assign done_evt = (done_s != done_seen);
  assign tdo     = sr[0];

  jdb_sync #(.W(1), .DEPTH(2)) u_done_sync (
    .clk (tck),
    .d   (done_tog_a),
    .q   (done_s)
  );

  // req_tog is left out of reset on purpose: it must only ever toggle,
  // otherwise the system side would see a phantom request.
  always_ff @(posedge tck) begin
    done_seen <= done_s;
    if (tap_rst) begin
      sr       <= '0;
      busy     <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_we   <= 1'b0;
    end else begin
      if (sel_hit && cap_en)
        sr <= {cmd_addr, rd_data, status_code(busy)};
      else if (sel_hit && shift_en)
        sr <= {tdi, sr[FW-1:1]};

      if (launch) begin
        cmd_addr <= fr_addr;
        cmd_data <= fr_data;
        cmd_we   <= (fr_op == OP_WRITE);
        req_tog  <= ~req_tog;
        busy     <= 1'b1;
      end else if (done_evt) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/jdb_sys_side.sv
module jdb_sys_side #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          sys_clk,
  input  logic          sys_rst,
  input  logic          req_tog_a,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_req,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] rd_data,
  output logic          done_tog,
  output logic          start
);
  logic req_s;
  logic req_seen;
  logic finish;

  jdb_sync #(.W(1), .DEPTH(2)) u_req_sync (
    .clk (sys_clk),
    .d   (req_tog_a),
    .q   (req_s)
  );

  assign start  = (req_s != req_seen) && !bus_req;
  assign finish = bus_req && bus_ack;

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      req_seen  <= req_s;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_data   <= '0;
      done_tog  <= 1'b0;
    end else if (start) begin
      req_seen  <= req_s;
      bus_req   <= 1'b1;
      bus_we    <= cmd_we;
      bus_addr  <= cmd_addr;
      bus_wdata <= cmd_data;
    end else if (finish) begin
      bus_req  <= 1'b0;
      done_tog <= ~done_tog;
      if (!bus_we) rd_data <= bus_rdata;
    end
  end
endmodule

// File: rtl/jtag_dbg_bridge.sv
module jtag_dbg_bridge #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          tck,
  input  logic          tap_rst,
  input  logic          tdi,
  output logic          tdo,
  input  logic          cap_en,
  input  logic          shift_en,
  input  logic          upd_en,
  input  logic [3:0]    chain_sel,
  input  logic          sys_clk,
  input  logic          sys_rst,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  input  logic          bus_ack
);
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_we;
  logic          req_tog;
  logic          done_tog;
  logic [DW-1:0] rd_data;
  logic          tck_busy;
  logic          tck_launch;
  logic          sys_start;

  jdb_tck_side #(.AW(AW), .DW(DW), .SEL_W(4), .SEL_IDX(1)) u_tck (
    .tck        (tck),
    .tap_rst    (tap_rst),
    .tdi        (tdi),
    .tdo        (tdo),
    .cap_en     (cap_en),
    .shift_en   (shift_en),
    .upd_en     (upd_en),
    .chain_sel  (chain_sel),
    .done_tog_a (done_tog),
    .rd_data    (rd_data),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_we     (cmd_we),
    .req_tog    (req_tog),
    .busy       (tck_busy),
    .launch     (tck_launch)
  );

  jdb_sys_side #(.AW(AW), .DW(DW)) u_sys (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .req_tog_a (req_tog),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_we    (cmd_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .rd_data   (rd_data),
    .done_tog  (done_tog),
    .start     (sys_start)
  );
endmodule

// File: rtl/jdb_checker.sv
module jdb_checker #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input logic          tck,
  input logic          tap_rst,
  input logic          tdo,
  input logic [3:0]    chain_sel,
  input logic          sys_clk,
  input logic          sys_rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          tck_busy,
  input logic          tck_launch,
  input logic          sys_start
);
  AST_REQ_HELD: assert property (@(posedge sys_clk) disable iff (sys_rst)
    bus_req && !bus_ack |=> bus_req); // R5
  AST_REQ_RELEASE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    bus_req && bus_ack |=> !bus_req); // R5
  AST_CMD_STABLE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R5
  AST_START_REQ: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sys_start |=> bus_req); // R3
  AST_UNSEL_QUIET: assert property (@(posedge tck) disable iff (tap_rst)
    (chain_sel != 4'b0010) |=> $stable(tdo)); // R2
  AST_LAUNCH_BUSY: assert property (@(posedge tck) disable iff (tap_rst)
    tck_launch |=> tck_busy); // R6
  AST_TAP_CLEAR: assert property (@(posedge tck)
    tap_rst |=> !tdo && !tck_busy); // R9
endmodule

bind jtag_dbg_bridge jdb_checker #(.AW(AW), .DW(DW)) u_chk (
  .tck        (tck),
  .tap_rst    (tap_rst),
  .tdo        (tdo),
  .chain_sel  (chain_sel),
  .sys_clk    (sys_clk),
  .sys_rst    (sys_rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .tck_busy   (tck_busy),
  .tck_launch (tck_launch),
  .sys_start  (sys_start)
);

// File: tb/jtag_dbg_bridge_tb.sv
module jtag_dbg_bridge_tb_top;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int FW = AW + DW + 2;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [DW-1:0] exp;   // expected response data field after completion
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{WR, 8'h10, 64'h1122334455667788, 64'h0},
    '{WR, 8'h2F, 64'hCAFEF00D12345678, 64'h0},
    '{RD, 8'h10, 64'h0,                64'h1122334455667788},
    '{WR, 8'h10, 64'hDEADBEEF00C0FFEE, 64'h1122334455667788},
    '{RD, 8'h2F, 64'h0,                64'hCAFEF00D12345678},
    '{RD, 8'h10, 64'h0,                64'hDEADBEEF00C0FFEE},
    '{RD, 8'h80, 64'h0,                64'h0},
    '{WR, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 64'h0},
    '{RD, 8'hFF, 64'h0,                64'hFFFFFFFFFFFFFFFF}
  };

  logic tck = 0, tap_rst = 1, tdi = 0, cap_en = 0, shift_en = 0, upd_en = 0;
  logic [3:0] chain_sel = 4'b0010;
  logic sys_clk = 0, sys_rst = 1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_req, bus_we, tdo;
  logic bus_ack = 0;

  int checks = 0, fails = 0, req_count = 0, ack_delay = 2;
  logic [AW-1:0] last_addr = '0;
  logic last_we = 0;
  logic [DW-1:0] mem [256];
  bit done_flag = 0;

  always #4 sys_clk = ~sys_clk;

  jtag_dbg_bridge #(.AW(AW), .DW(DW)) dut_i (
    .tck(tck), .tap_rst(tap_rst), .tdi(tdi), .tdo(tdo), .cap_en(cap_en),
    .shift_en(shift_en), .upd_en(upd_en), .chain_sel(chain_sel),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_ack(bus_ack)
  );

  // Debug bus model with programmable acknowledge delay
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    forever begin
      @(negedge sys_clk);
      if (bus_req) begin
        repeat (ack_delay) @(negedge sys_clk);
        req_count++;
        last_addr = bus_addr;
        last_we   = bus_we;
        bus_rdata = mem[bus_addr];
        if (bus_we) mem[bus_addr] = bus_wdata;
        bus_ack = 1;
        @(negedge sys_clk);
        bus_ack = 0;
      end
    end
  end

  function automatic logic [FW-1:0] mk(input logic [1:0] op, input logic [AW-1:0] a,
                                        input logic [DW-1:0] d);
    return {a, d, op};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tck_cycle();
    #15 tck = 1;
    #15 tck = 0;
  endtask

  task automatic scan(input logic [FW-1:0] cmd, output logic [FW-1:0] resp);
    cap_en = 1; tck_cycle(); cap_en = 0;
    shift_en = 1;
    for (int i = 0; i < FW; i++) begin
      resp[i] = tdo;
      tdi = cmd[i];
      tck_cycle();
    end
    shift_en = 0;
    upd_en = 1; tck_cycle(); upd_en = 0;
    tck_cycle();
  endtask

  task automatic poll(output logic [FW-1:0] resp);
    int n = 0;
    scan(mk(NOP, '0, '0), resp);
    while (resp[1:0] != 2'b00 && n < 200) begin
      scan(mk(NOP, '0, '0), resp);
      n++;
    end
    if (n >= 200) check(0, "R6 poll timeout", 64'(resp[1:0]), 64'h0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    check(0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    logic [FW-1:0] r;
    int c0;
    repeat (5) tck_cycle();
    repeat (4) @(posedge sys_clk);
    #1 sys_rst = 0;
    tap_rst = 0;
    tck_cycle();

    // Reset state: R9
    check(bus_req == 0, "R9 bus_req after reset", 64'(bus_req), 64'h0);
    scan(mk(NOP, '0, '0), r);
    check(r == '0, "R9 reset response frame", r[DW+1:2], 64'h0);

    // Table walk: R1 R3 R4 R10
    for (int v = 0; v < NV; v++) begin
      scan(mk(VECS[v].op, VECS[v].addr, VECS[v].data), r);
      poll(r);
      check(r[FW-1:DW+2] == VECS[v].addr, "R1 response address field",
            64'(r[FW-1:DW+2]), 64'(VECS[v].addr));
      check(r[DW+1:2] == VECS[v].exp, "R10 response data field", r[DW+1:2], VECS[v].exp);
      check(last_addr == VECS[v].addr && last_we == (VECS[v].op == WR),
            "R3 bus address and direction", {55'h0, last_we, last_addr},
            {55'h0, VECS[v].op == WR, VECS[v].addr});
      if (VECS[v].op == WR)
        check(mem[VECS[v].addr] == VECS[v].data, "R4 written data", mem[VECS[v].addr],
              VECS[v].data);
    end

    // No-op codes: R7
    c0 = req_count;
    scan(mk(NOP, 8'h33, 64'h5), r);
    scan(mk(RSV, 8'h44, 64'h6), r);
    repeat (200) @(posedge sys_clk);
    scan(mk(NOP, '0, '0), r);
    check(req_count == c0, "R7 no transaction for op 00/11", 64'(req_count), 64'(c0));
    check(r[FW-1:DW+2] == 8'hFF && r[1:0] == 2'b00, "R7 address and status unchanged",
          64'(r[FW-1:DW+2]), 64'hFF);

    // Unselected chain: R2
    chain_sel = 4'b0100;
    scan(mk(WR, 8'h55, 64'hABCD), r);
    chain_sel = 4'b0110;
    scan(mk(WR, 8'h56, 64'hABCE), r);
    chain_sel = 4'b0010;
    repeat (200) @(posedge sys_clk);
    scan(mk(NOP, '0, '0), r);
    check(req_count == c0, "R2 no transaction when unselected", 64'(req_count), 64'(c0));
    check(mem[8'h55] == 0 && mem[8'h56] == 0, "R2 memory untouched", mem[8'h55], 64'h0);
    check(r[FW-1:DW+2] == 8'hFF, "R2 address field unchanged", 64'(r[FW-1:DW+2]), 64'hFF);

    // Busy status and command while pending: R6 R8
    ack_delay = 3000;
    scan(mk(WR, 8'h60, 64'h0123456789ABCDEF), r);
    scan(mk(WR, 8'h61, 64'h7777), r);
    check(r[1:0] == 2'b11, "R6 status busy while pending", 64'(r[1:0]), 64'h3);
    poll(r);
    check(r[1:0] == 2'b00, "R6 status done", 64'(r[1:0]), 64'h0);
    check(req_count == c0 + 1, "R8 only one transaction", 64'(req_count), 64'(c0 + 1));
    check(mem[8'h61] == 0 && mem[8'h60] == 64'h0123456789ABCDEF, "R8 dropped write",
          mem[8'h61], 64'h0);
    check(r[FW-1:DW+2] == 8'h60, "R8 address of pending command", 64'(r[FW-1:DW+2]),
          64'h60);

    // TAP reset in flight: R9
    scan(mk(RD, 8'h10, 64'h0), r);
    scan(mk(NOP, '0, '0), r);
    check(r[1:0] == 2'b11, "R9 busy before reset", 64'(r[1:0]), 64'h3);
    tap_rst = 1; tck_cycle(); tck_cycle(); tap_rst = 0;
    scan(mk(NOP, '0, '0), r);
    check(r[1:0] == 2'b00 && r[FW-1:DW+2] == '0, "R9 status and address cleared",
          64'(r[FW-1:DW+2]), 64'h0);
    ack_delay = 2;
    repeat (3200) @(posedge sys_clk);
    repeat (4) tck_cycle();
    scan(mk(RD, 8'h2F, 64'h0), r);
    poll(r);
    check(r[DW+1:2] == 64'hCAFEF00D12345678, "R9 read after reset", r[DW+1:2],
          64'hCAFEF00D12345678);

    finish_run();
  end
endmodule